// File: doc/BRIEF.md
# VLAN-Aware Three-Port Forwarding Lookup

This block chooses the egress ports for each packet in a three-port switch. Port 0 faces the host and ports 1 and 2 face the line. Software loads two small tables through a single write port. The first is a VLAN table, with one member mask and one flood mask per VLAN ID. The second is a unicast table, keyed on VLAN ID plus destination MAC, that names one destination port. For each lookup request the block takes the ingress port, the VLAN ID, the destination MAC, a host "directed" flag and a directed destination. One clock later it returns a three-bit egress mask.

VLAN-aware mode confines forwarding to the members of the packet's VLAN. Two VLANs can therefore split the switch into two independent MACs: one VLAN has members {0,1}, the other has members {0,2}, both have empty flood masks, and their unicast entries point at port 0. In that setup no packet ever crosses between ports 1 and 2. Directed host traffic skips the tables. With VLAN awareness off, only the MAC is matched and unknown destinations are flooded.

Top module: `fwd_lookup`

## Requirements
- R1: After reset, `res_valid` and `res_mask` are 0 and every table entry is invalid. A VLAN-aware lookup then returns 0, and a non-aware lookup floods to every port except the ingress port.
- R2: `res_valid` is high exactly one clock after `req_valid`, for one cycle per request. `res_mask` is 0 whenever `res_valid` is low.
- R3: A request with `req_directed`=1 and `req_port`=0 ignores both tables and returns only bit `req_dport` of the mask, with bit 0 cleared. Bit n of the mask stands for port n, and a `req_dport` of 3 gives 0.
- R4: In VLAN-aware mode, if no valid VLAN entry carries `req_vid`, the result is 0.
- R5: In VLAN-aware mode, if the ingress port's bit is clear in the VLAN's member mask, the result is 0.
- R6: In VLAN-aware mode, a valid unicast entry whose VLAN ID and MAC both match gives the bit of its port number, ANDed with the member mask and with the ingress bit cleared.
- R7: In VLAN-aware mode, an unknown destination gives the VLAN's flood mask ANDed with its member mask, with the ingress bit cleared. An empty flood mask forwards nowhere.
- R8: When several valid entries of one table match, the entry with the lowest index decides.
- R9: With `vlan_aware`=0, VLAN membership and entry VLAN IDs are ignored. A MAC hit gives its port bit, a miss gives 3'b111, and the ingress bit is cleared in both cases.
- R10: The ingress port's bit is never set in a valid result.
- R11: With the two-VLAN isolation setup, a packet entering on port 1 never gets bit 2, and a packet entering on port 2 never gets bit 1.
- R12: A write with `cfg_ent_valid`=0 removes that entry from all later lookups. `cfg_tbl`=0 selects the VLAN table and 1 selects the unicast table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vlan_aware | input | 1 | Selects VLAN-aware lookup |
| cfg_we | input | 1 | Table write strobe |
| cfg_tbl | input | 1 | 0 = VLAN table, 1 = unicast table |
| cfg_idx | input | IDX_W | Entry index |
| cfg_ent_valid | input | 1 | Valid bit written to the entry |
| cfg_vid | input | VID_W | VLAN ID of the entry |
| cfg_mac | input | MAC_W | MAC of a unicast entry |
| cfg_members | input | 3 | Member mask of a VLAN entry |
| cfg_flood | input | 3 | Flood mask of a VLAN entry |
| cfg_port | input | 2 | Destination port of a unicast entry |
| req_valid | input | 1 | Lookup request strobe |
| req_port | input | 2 | Ingress port |
| req_vid | input | VID_W | VLAN ID received with the packet |
| req_mac | input | MAC_W | Destination MAC |
| req_directed | input | 1 | Host packet with a named destination |
| req_dport | input | 2 | Destination of a directed packet |
| res_valid | output | 1 | Result strobe |
| res_mask | output | 3 | Egress port mask |

## Verification
Every lookup result is registered once, so the mask and its strobe are due on the first rising edge after the request. A table write takes effect on its own edge, so it affects any request presented after that edge. The bench drives each request on a falling edge and compares `res_valid` and `res_mask` on the next falling edge, which sits half a period after the edge that registers the result. It then drops the request, so every vector is compared against exactly one expected mask. Table writes are driven the same way and finish before the next request is driven.

// File: rtl/fwd_lookup.sv
module fwd_lookup #(
  parameter int UC_N  = 16,
  parameter int VL_N  = 16,
  parameter int VID_W = 12,
  parameter int MAC_W = 48,
  localparam int IDX_W = $clog2((UC_N > VL_N) ? UC_N : VL_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vlan_aware,
  input  logic             cfg_we,
  input  logic             cfg_tbl,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_ent_valid,
  input  logic [VID_W-1:0] cfg_vid,
  input  logic [MAC_W-1:0] cfg_mac,
  input  logic [2:0]       cfg_members,
  input  logic [2:0]       cfg_flood,
  input  logic [1:0]       cfg_port,
  input  logic             req_valid,
  input  logic [1:0]       req_port,
  input  logic [VID_W-1:0] req_vid,
  input  logic [MAC_W-1:0] req_mac,
  input  logic             req_directed,
  input  logic [1:0]       req_dport,
  output logic             res_valid,
  output logic [2:0]       res_mask
);

  logic             vl_v   [VL_N];
  logic [VID_W-1:0] vl_vid [VL_N];
  logic [2:0]       vl_mem [VL_N];
  logic [2:0]       vl_fld [VL_N];
  logic             uc_v   [UC_N];
  logic [VID_W-1:0] uc_vid [UC_N];
  logic [MAC_W-1:0] uc_mac [UC_N];
  logic [1:0]       uc_prt [UC_N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < VL_N; i++) vl_v[i] <= 1'b0;
      for (int i = 0; i < UC_N; i++) uc_v[i] <= 1'b0;
    end else if (cfg_we) begin
      if (!cfg_tbl && int'(cfg_idx) < VL_N) begin
        vl_v[cfg_idx]   <= cfg_ent_valid;
        vl_vid[cfg_idx] <= cfg_vid;
        vl_mem[cfg_idx] <= cfg_members;
        vl_fld[cfg_idx] <= cfg_flood;
      end
      if (cfg_tbl && int'(cfg_idx) < UC_N) begin
        uc_v[cfg_idx]   <= cfg_ent_valid;
        uc_vid[cfg_idx] <= cfg_vid;
        uc_mac[cfg_idx] <= cfg_mac;
        uc_prt[cfg_idx] <= cfg_port;
      end
    end
  end

  logic       vl_hit, uc_hit;
  logic [2:0] mem, fld, uc_dst, nxt;
  wire  [2:0] ing = 3'b001 << req_port;

  always_comb begin
    vl_hit = 1'b0; mem = 3'b000; fld = 3'b000;
    for (int i = VL_N - 1; i >= 0; i--)
      if (vl_v[i] && vl_vid[i] == req_vid) begin
        vl_hit = 1'b1; mem = vl_mem[i]; fld = vl_fld[i];
      end
    uc_hit = 1'b0; uc_dst = 3'b000;
    for (int i = UC_N - 1; i >= 0; i--)
      if (uc_v[i] && uc_mac[i] == req_mac && (!vlan_aware || uc_vid[i] == req_vid)) begin
        uc_hit = 1'b1; uc_dst = 3'b001 << uc_prt[i];
      end
  end

  always_comb begin
    if (req_directed && req_port == 2'd0)
      nxt = (3'b001 << req_dport) & ~ing;
    else if (!vlan_aware)
      nxt = (uc_hit ? uc_dst : 3'b111) & ~ing;
    else if (!vl_hit || (mem & ing) == 3'b000)
      nxt = 3'b000;
    else
      nxt = (uc_hit ? uc_dst : fld) & mem & ~ing;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_mask  <= 3'b000;
    end else begin
      res_valid <= req_valid;
      res_mask  <= req_valid ? nxt : 3'b000;
    end
  end

endmodule

module fwd_lookup_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_port,
  input logic       req_directed,
  input logic [1:0] req_dport,
  input logic       res_valid,
  input logic [2:0] res_mask
);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> res_mask == 3'b000);

  assert_no_hairpin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (res_mask & (3'b001 << $past(req_port))) == 3'b000);

  assert_directed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_directed && req_port == 2'd0)
      |=> res_mask == ((3'b001 << $past(req_dport)) & 3'b110));

endmodule

bind fwd_lookup fwd_lookup_chk u_chk (.*);

// File: tb/fwd_lookup_bench.sv
module fwd_lookup_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0, rst_n = 1'b0, vlan_aware = 1'b0;
  logic cfg_we = 1'b0, cfg_tbl = 1'b0, cfg_ent_valid = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [11:0] cfg_vid = '0, req_vid = '0;
  logic [47:0] cfg_mac = '0, req_mac = '0;
  logic [2:0] cfg_members = '0, cfg_flood = '0;
  logic [1:0] cfg_port = '0, req_port = '0, req_dport = '0;
  logic req_valid = 1'b0, req_directed = 1'b0;
  logic res_valid;
  logic [2:0] res_mask;

  fwd_lookup u_fwd_lookup (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, errors = 0;

  logic        m_vv [N]; logic [11:0] m_vvid [N]; logic [2:0] m_mem [N]; logic [2:0] m_fld [N];
  logic        m_uv [N]; logic [11:0] m_uvid [N]; logic [47:0] m_umac [N]; logic [1:0] m_uprt [N];

  logic [47:0] macs [5];
  logic [11:0] vids [3];

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(logic tbl, int idx, logic v, logic [11:0] vid, logic [47:0] mac,
                    logic [2:0] mem, logic [2:0] fld, logic [1:0] prt);
    @(negedge clk);
    cfg_we = 1; cfg_tbl = tbl; cfg_idx = 4'(idx); cfg_ent_valid = v; cfg_vid = vid;
    cfg_mac = mac; cfg_members = mem; cfg_flood = fld; cfg_port = prt;
    if (!tbl) begin m_vv[idx] = v; m_vvid[idx] = vid; m_mem[idx] = mem; m_fld[idx] = fld; end
    else begin m_uv[idx] = v; m_uvid[idx] = vid; m_umac[idx] = mac; m_uprt[idx] = prt; end
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic logic [2:0] model(logic aw, logic [1:0] p, logic [11:0] vid,
                                       logic [47:0] mac, logic dir, logic [1:0] dp,
                                       output string tag);
    int vi = -1, ui = -1;
    logic [2:0] ib = 3'b001 << p;
    logic [2:0] dst;
    for (int i = 0; i < N; i++) if (vi < 0 && m_vv[i] && m_vvid[i] == vid) vi = i;
    for (int i = 0; i < N; i++)
      if (ui < 0 && m_uv[i] && m_umac[i] == mac && (!aw || m_uvid[i] == vid)) ui = i;
    dst = (ui >= 0) ? (3'b001 << m_uprt[ui]) : 3'b000;
    if (dir && p == 0) begin tag = "R3 directed"; return (3'b001 << dp) & 3'b110; end
    if (!aw) begin tag = "R9 non-aware"; return ((ui >= 0) ? dst : 3'b111) & ~ib; end
    if (vi < 0) begin tag = "R4 vlan miss"; return 3'b000; end
    if ((m_mem[vi] & ib) == 0) begin tag = "R5 non-member"; return 3'b000; end
    if (ui >= 0) begin tag = "R6/R8 unicast hit"; return dst & m_mem[vi] & ~ib; end
    tag = "R7 flood"; return m_fld[vi] & m_mem[vi] & ~ib;
  endfunction

  task automatic lookup(string phase, logic aw, logic [1:0] p, logic [11:0] vid,
                        logic [47:0] mac, logic dir, logic [1:0] dp);
    string tag;
    logic [2:0] exp;
    @(negedge clk);
    vlan_aware = aw; req_valid = 1; req_port = p; req_vid = vid; req_mac = mac;
    req_directed = dir; req_dport = dp;
    exp = model(aw, p, vid, mac, dir, dp, tag);
    @(negedge clk);
    req_valid = 0;
    check({"R2 strobe ", phase}, {2'b00, res_valid}, 3'b001);
    check({tag, " ", phase}, res_mask, exp);
    check({"R10 ingress ", phase}, res_mask & (3'b001 << p), 3'b000);
  endtask

  task automatic sweep(string phase, logic isolation);
    for (int a = 0; a < 2; a++)
      for (int p = 0; p < 3; p++)
        for (int v = 0; v < 3; v++)
          for (int m = 0; m < 5; m++)
            for (int d = 0; d < 2; d++)
              for (int q = 0; q < 4; q++) begin
                lookup(phase, a[0], 2'(p), vids[v], macs[m], d[0], 2'(q));
                if (isolation && a == 1 && p == 1) check("R11 port1 isolated", res_mask & 3'b100, 3'b000);
                if (isolation && a == 1 && p == 2) check("R11 port2 isolated", res_mask & 3'b010, 3'b000);
              end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_vv[i] = 0; m_uv[i] = 0; end
    macs[0] = 48'h02_00_00_00_00_0A; macs[1] = 48'h02_00_00_00_00_0B;
    macs[2] = 48'h02_00_00_00_00_0C; macs[3] = 48'h02_00_00_00_00_0D;
    macs[4] = 48'h02_00_00_00_00_0E;
    vids[0] = 12'd10; vids[1] = 12'd20; vids[2] = 12'd30;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {2'b00, res_valid}, 3'b000);
    check("R1 reset mask", res_mask, 3'b000);
    rst_n = 1;
    lookup("R1 empty", 1'b1, 2'd1, 12'd10, macs[0], 1'b0, 2'd0);
    lookup("R1 empty", 1'b0, 2'd2, 12'd10, macs[0], 1'b0, 2'd0);

    // R11 two-VLAN isolation setup, R8 duplicate at higher index
    wr(0, 0, 1, 12'd10, '0, 3'b011, 3'b000, 0);
    wr(0, 1, 1, 12'd20, '0, 3'b101, 3'b000, 0);
    wr(1, 0, 1, 12'd10, macs[0], 0, 0, 2'd0);
    wr(1, 1, 1, 12'd10, macs[1], 0, 0, 2'd0);
    wr(1, 2, 1, 12'd20, macs[2], 0, 0, 2'd0);
    wr(1, 3, 1, 12'd10, macs[0], 0, 0, 2'd1);
    wr(1, 5, 1, 12'd10, macs[3], 0, 0, 2'd1);
    sweep("dual", 1'b1);

    // R7 flooding VLAN, R8 VLAN duplicate
    wr(0, 2, 1, 12'd30, '0, 3'b111, 3'b110, 0);
    wr(0, 7, 1, 12'd30, '0, 3'b001, 3'b000, 0);
    wr(1, 8, 1, 12'd30, macs[4], 0, 0, 2'd2);
    sweep("flood", 1'b0);

    // R12 invalidation
    wr(1, 0, 0, 12'd10, macs[0], 0, 0, 2'd0);
    wr(0, 2, 0, 12'd30, '0, 3'b111, 3'b110, 0);
    sweep("R12 invalidated", 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule